// File: doc/BRIEF.md
# Tone-Shift Audio Bit Recovery

This block turns a stream of signed 8-bit audio samples, taken at eight samples per bit period, into decoded data bits. The discriminator multiplies every sample by the sample from half a bit earlier. A low-pass filter built only from adders and arithmetic shifts smooths the product. The sign of the filter output is kept in a short history of sliced values.

A phase accumulator advances once per accepted sample. Whenever the two newest sliced values differ, the accumulator is pulled one step towards the middle of the bit. When it wraps, the block makes a bit decision by majority over the three newest sliced values. The output bit is then NRZI-decoded against the previous decision.

Both the sample input and the bit output use a valid/ready handshake. A sample is taken only on a cycle where `smp_valid` and `smp_ready` are both high. A decoded bit appears on `bit_data` one cycle after the sample that completed it. That bit is held, together with `bit_valid`, until `bit_ready` is high. While a held bit is not accepted, `smp_ready` is low. This back-pressure means no bit is ever lost or overwritten.

Top module: `afsk_demod`

## Requirements
- R1: After reset, `bit_valid` is 0 and `smp_ready` is 1. The delay line, the filter state, the sliced history, the phase and the previous decision are all 0.
- R2: Each accepted sample s is multiplied by the sample accepted four samples earlier, which is 0 until four samples have been taken. The signed product is shifted arithmetically right by 2, giving x.
- R3: The filter output is y = x_prev + x + (y_prev>>>1) + (y_prev>>>3) + (y_prev>>>5). All terms are signed 16-bit values, and x_prev and y_prev come from the previous accepted sample.
- R4: Each accepted sample shifts a 1 into the sliced history when y > 0, and a 0 otherwise.
- R5: The phase ranges over 0..63. Each accepted sample adds 8 to it. When the result is 64 or more, 64 is subtracted and a bit decision is made.
- R6: When the two newest sliced values differ, the phase is first moved by 1, before the step of 8 is added. The move is upward if the phase is below 32 and downward otherwise.
- R7: The raw decision is 1 when at least two of the three newest sliced values are 1.
- R8: The output bit is 1 when the raw decision equals the previous raw decision, and 0 when they differ.
- R9: While `bit_valid` is 1 and `bit_ready` is 0, `bit_data` and `bit_valid` hold, and `smp_ready` is 0, so no sample is accepted.
- R10: Each decision raises `bit_valid` in the next cycle, and `bit_valid` rises at no other time. The bit is consumed on the first cycle where `bit_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample present |
| smp_data | input | 8 | Signed audio sample |
| smp_ready | output | 1 | Block can take a sample |
| bit_valid | output | 1 | Decoded bit present |
| bit_data | output | 1 | Decoded data bit |
| bit_ready | input | 1 | Consumer takes the bit |

## Verification
Filter state feeds back into itself, so a wrong filter value does not die out quickly. It shows as changed sliced values, which appear at the ports as wrong bits over several bit periods. A phase error appears within one bit period, as a bit that arrives a sample early or late. That shift puts `bit_valid` on the wrong cycle relative to the reference stream. A fault in the NRZI stage or the majority vote corrupts the very next bit that is delivered. A fault in the handshake shows in the first stalled cycle, as a bit that changes or a sample that is accepted.

// File: rtl/afsk_pkg.sv
package afsk_pkg;
  // two-of-three vote over the newest sliced values
  function automatic logic vote3(input logic [2:0] b);
    return (b[0] & b[1]) | (b[0] & b[2]) | (b[1] & b[2]);
  endfunction
endpackage

// File: rtl/afsk_mixer.sv
module afsk_mixer #(
  parameter int SAMP_W = 8,
  parameter int DLY    = 4,
  parameter int ACC_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fire,
  input  logic signed [SAMP_W-1:0] smp,
  output logic signed [ACC_W-1:0]  prod
);
  localparam int MUL_W = 2 * SAMP_W;

  logic signed [SAMP_W-1:0] tap [DLY];
  logic signed [MUL_W-1:0]  mul;

  // R2: delay line, newest at tap[0]
  for (genvar i = 0; i < DLY; i++) begin : g_tap
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)    tap[i] <= '0;
        else if (fire) tap[i] <= smp;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n)    tap[i] <= '0;
        else if (fire) tap[i] <= tap[i-1];
      end
    end
  end

  assign mul  = smp * tap[DLY-1];
  assign prod = ACC_W'(mul >>> 2);
endmodule

// File: rtl/afsk_lpf.sv
module afsk_lpf #(
  parameter int ACC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fire,
  input  logic signed [ACC_W-1:0] x_in,
  output logic signed [ACC_W-1:0] y_out
);
  logic signed [ACC_W-1:0] x_q, y_q;

  // R3: shift-only recursive low-pass
  assign y_out = x_q + x_in + (y_q >>> 1) + (y_q >>> 3) + (y_q >>> 5);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (fire) begin
      x_q <= x_in;
      y_q <= y_out;
    end
  end
endmodule

// File: rtl/afsk_bitsync.sv
module afsk_bitsync
  import afsk_pkg::*;
#(
  parameter int SPB     = 8,
  parameter int PH_STEP = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic pos,
  output logic decide,
  output logic data_bit
);
  localparam int PH_MAX  = SPB * PH_STEP;
  localparam int PH_HALF = PH_MAX / 2;
  localparam int PH_W    = $clog2(PH_MAX + PH_STEP + 2);

  logic [2:0]      hist, hist_n;
  logic [PH_W-1:0] phase, phase_adj, phase_sum, phase_nxt;
  logic            edge_w, wrap, raw, prev_raw;

  assign hist_n = {hist[1:0], pos};                    // R4
  assign edge_w = hist_n[0] ^ hist_n[1];

  always_comb begin                                    // R6
    phase_adj = phase;
    if (edge_w) begin
      if (phase < PH_W'(PH_HALF)) phase_adj = phase + PH_W'(1);
      else                        phase_adj = phase - PH_W'(1);
    end
  end

  assign phase_sum = phase_adj + PH_W'(PH_STEP);       // R5
  assign wrap      = phase_sum >= PH_W'(PH_MAX);
  assign phase_nxt = wrap ? phase_sum - PH_W'(PH_MAX) : phase_sum;

  assign raw      = vote3(hist_n);                     // R7
  assign decide   = fire && wrap;
  assign data_bit = ~(raw ^ prev_raw);                 // R8

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist     <= '0;
      phase    <= '0;
      prev_raw <= 1'b0;
    end else if (fire) begin
      hist  <= hist_n;
      phase <= phase_nxt;
      if (wrap) prev_raw <= raw;
    end
  end

  p_phase_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phase < PH_W'(PH_MAX));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !edge_w && phase < PH_W'(PH_MAX - PH_STEP))
      |=> phase == $past(phase) + PH_W'(PH_STEP));

  p_nudge_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && edge_w && phase < PH_W'(PH_HALF))
      |=> phase == $past(phase) + PH_W'(PH_STEP + 1));
endmodule

// File: rtl/afsk_demod.sv
module afsk_demod #(
  parameter int SAMP_W  = 8,
  parameter int SPB     = 8,
  parameter int PH_STEP = 8,
  parameter int ACC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [SAMP_W-1:0] smp_data,
  output logic              smp_ready,
  output logic              bit_valid,
  output logic              bit_data,
  input  logic              bit_ready
);
  localparam int DLY = SPB / 2;

  logic                    fire, decide, dbit;
  logic signed [ACC_W-1:0] prod, yv;

  assign smp_ready = !bit_valid || bit_ready;          // R9
  assign fire      = smp_valid && smp_ready;

  afsk_mixer #(.SAMP_W(SAMP_W), .DLY(DLY), .ACC_W(ACC_W)) u_mix (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .smp(signed'(smp_data)), .prod(prod));

  afsk_lpf #(.ACC_W(ACC_W)) u_lpf (
    .clk(clk), .rst_n(rst_n), .fire(fire), .x_in(prod), .y_out(yv));

  afsk_bitsync #(.SPB(SPB), .PH_STEP(PH_STEP)) u_sync (
    .clk(clk), .rst_n(rst_n), .fire(fire), .pos(yv > 0),
    .decide(decide), .data_bit(dbit));

  always_ff @(posedge clk) begin                       // R10
    if (!rst_n) begin
      bit_valid <= 1'b0;
      bit_data  <= 1'b0;
    end else if (decide) begin
      bit_valid <= 1'b1;
      bit_data  <= dbit;
    end else if (bit_ready) begin
      bit_valid <= 1'b0;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_ready) |=> (bit_valid && $stable(bit_data)));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_ready) |-> !smp_ready);

  p_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_valid) |-> $past(fire));
endmodule

// File: tb/tb_afsk_demod.sv
module tb_afsk_demod;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [7:0] smp_data = '0;
  logic smp_ready, bit_valid, bit_data;
  logic bit_ready = 1'b0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  // reference state
  int m_dl [4];
  int m_x, m_y, m_ph;
  bit [2:0] m_hist;
  bit m_prev;
  int q_cnt;
  bit q_bit;

  always #4 clk = ~clk;

  afsk_demod dut (.clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_data(smp_data), .smp_ready(smp_ready), .bit_valid(bit_valid),
    .bit_data(bit_data), .bit_ready(bit_ready));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic m_reset();
    foreach (m_dl[i]) m_dl[i] = 0;
    m_x = 0; m_y = 0; m_ph = 0; m_hist = '0; m_prev = 1'b0; q_cnt = 0; q_bit = 1'b0;
  endtask

  // reference per sample: R2 R3 R4 R6 R5 R7 R8
  task automatic m_step(input int s, output bit dec, output bit ob);
    int x, y, p;
    bit raw;
    x = (s * m_dl[3]) >>> 2;
    for (int i = 3; i > 0; i--) m_dl[i] = m_dl[i-1];
    m_dl[0] = s;
    y = m_x + x + (m_y >>> 1) + (m_y >>> 3) + (m_y >>> 5);
    m_x = x; m_y = y;
    m_hist = {m_hist[1:0], (y > 0)};
    p = m_ph;
    if (m_hist[0] != m_hist[1]) p = (p < 32) ? p + 1 : p - 1;
    p = p + 8;
    dec = (p >= 64);
    if (dec) p = p - 64;
    m_ph = p;
    raw = (m_hist[0] + m_hist[1] + m_hist[2]) >= 2;
    ob = (raw == m_prev);
    if (dec) m_prev = raw;
  endtask

  task automatic cycle(input bit v, input int s, input bit rdy);
    bit dec, ob;
    @(negedge clk);
    smp_valid = v; smp_data = 8'(s); bit_ready = rdy;
    #1;
    check(bit_valid == (q_cnt != 0), "R10 bit_valid", int'(bit_valid), int'(q_cnt != 0));
    if (bit_valid && q_cnt != 0)
      check(bit_data == q_bit, "R8 bit_data", int'(bit_data), int'(q_bit));
    check(smp_ready == (q_cnt == 0 || rdy), "R9 smp_ready", int'(smp_ready), int'(q_cnt == 0 || rdy));
    if (rdy) q_cnt = 0;
    if (v && smp_ready) begin
      m_step(s, dec, ob);
      if (dec) begin q_cnt = 1; q_bit = ob; end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_valid = 1'b0; bit_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_reset();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        summary();
      end
    end
  end

  initial begin
    real ph;
    bit tone;
    int s;
    void'($urandom(32'd4711));
    do_reset();
    #1;
    // R1 reset state
    check(bit_valid == 1'b0, "R1 bit_valid", int'(bit_valid), 0);
    check(smp_ready == 1'b1, "R1 smp_ready", int'(smp_ready), 1);

    // R5 silence: first decision after the eighth sample, bit 1 (R8)
    for (int i = 0; i < 8; i++) cycle(1, 0, 1);
    cycle(0, 0, 0);
    check(bit_valid == 1'b1, "R5 first decision", int'(bit_valid), 1);
    check(bit_data == 1'b1, "R8 silence bit", int'(bit_data), 1);
    // R9 stall: bit held and sample refused
    cycle(1, 77, 0);
    check(smp_ready == 1'b0, "R9 refused", int'(smp_ready), 0);
    cycle(1, 77, 1);

    // tone stream, NRZI coded random bits, random handshakes (R2 R3 R4 R6 R7)
    ph = 0.0; tone = 1'b0;
    for (int b = 0; b < 600; b++) begin
      if ($urandom_range(1, 0) == 0) tone = ~tone;
      for (int k = 0; k < 8; k++) begin
        s = $rtoi(110.0 * $sin(ph));
        do begin
          cycle($urandom_range(9, 0) < 7, s, $urandom_range(9, 0) < 6);
        end while (!(smp_valid && smp_ready));
        ph = ph + 2.0 * 3.14159265 * (tone ? 2200.0 : 1200.0) / 9600.0;
      end
    end

    // random full-scale noise and extremes (R2 R3 overflow corners)
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      case ($urandom_range(3, 0))
        0: s = -128;
        1: s = 127;
        default: s = $signed(8'($urandom_range(255, 0)));
      endcase
      cycle($urandom_range(1, 0) == 1, s, $urandom_range(3, 0) != 0);
    end
    for (int i = 0; i < 4; i++) cycle(0, 0, 1);

    done = 1'b1;
    summary();
  end
endmodule